// File: doc/BRIEF.md
# Bitstream directory scanner

This block walks a fixed window of a byte-wide memory and builds a directory of the configuration bitstreams stored there. It reads one byte at a time through a synchronous read port. Each bitstream is recognised by three marker bytes: a preamble, a later control-register byte, and a closing postamble. For every bitstream found, the address of the byte that follows its preamble is stored in an eight-entry table. After the scan, a loader can look up where each stored image begins without knowing the memory layout in advance.

The scan runs after a one-cycle `start` pulse and stops at the end of the window. `done` then stays high until the next pulse. The table is read through a combinational select port. `count` gives the number of valid entries. `overflow` reports that more bitstreams were present than the table holds.

The controller is a single state machine with these states:
- `S_IDLE`: after reset.
- `S_PRE_REQ` / `S_PRE_CHK`: search for a preamble.
- `S_CTRL_REQ` / `S_CTRL_CHK`: search for the control-register byte.
- `S_POST_REQ` / `S_POST_CHK`: search for the postamble.
- `S_DONE`: scan finished.

Each REQ state issues one read and always moves to its CHK state. A CHK state leaves as follows:
- It goes to `S_DONE` when the next address reaches the end of the window.
- When its marker matches, it moves to the REQ state of the next phase. From `S_POST_CHK` this is `S_PRE_REQ`, after a skip of one extra byte.
- Otherwise it returns to its own REQ state at the next address.

`start` moves any state to `S_PRE_REQ`.

Top module: `bsdir_scan`

## Requirements
- R1: After reset, `done`, `busy`, `mem_rd` and `overflow` are 0, `count` is 0 and every table entry reads 0.
- R2: A `start` pulse clears the table, `count` and `overflow` and begins the scan. In the cycle after the pulse, `mem_rd` is 1 with `mem_addr` = 0x0400.
- R3: Reads are single-byte, with `mem_rdata` taken one cycle after `mem_rd`. Within a scan, read addresses strictly increase and stay within 0x0400..0x0FFF.
- R4: While searching for a preamble, a byte equal to 0xB2 at address A stores A+1 in the next free table entry and increments `count`. Entries are stored in order of discovery, starting at select 0.
- R5: After a preamble, bytes are passed over until one equals the control-register value (parameter, default 0x00). Preamble bytes seen in this phase are not recorded.
- R6: After the control-register byte, bytes are passed over until a postamble 0x4D is seen at address P. The byte at P+1 is skipped unexamined, and the preamble search resumes at P+2.
- R7: In every phase, a byte read at address A is examined only if A+1 is below 0x1000. Otherwise the scan ends, `busy` falls and `done` rises. A bitstream cut off by the end of the window still ends the scan cleanly.
- R8: With eight entries stored, a further preamble is not recorded and sets `overflow`. Its control-register and postamble skipping still applies, and the scan runs to the end of the window.
- R9: `done`, `count`, `overflow` and the table hold their values until the next `start`. Selecting an entry at or beyond `count` returns 0.
- R10: A `start` pulse during a scan abandons it and restarts from a cleared table.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | One-cycle pulse: clear and begin a scan |
| mem_rd | output | 1 | Read request to the memory |
| mem_addr | output | 16 | Read address |
| mem_rdata | input | 8 | Read data, valid one cycle after `mem_rd` |
| busy | output | 1 | Scan in progress |
| done | output | 1 | Scan finished, results stable |
| count | output | 4 | Number of valid table entries |
| overflow | output | 1 | A preamble was found with the table full |
| tbl_sel | input | 3 | Table entry select |
| tbl_ptr | output | 16 | Start pointer stored in the selected entry |

## Verification
The hardest situations to reach from the ports involve the end of the window. They are a marker sitting in the last one or two bytes, and a postamble whose skip byte lands exactly on the boundary. Random memory contents almost never produce these. Directed images therefore place preambles, control bytes and postambles at 0x0FFD through 0x0FFF. Other images plant markers inside the wrong phase, and one fills the table past eight entries. Seeded random images with embedded bitstreams are then compared with a bench scan model that follows the requirements.

// File: rtl/bsdir_pkg.sv
package bsdir_pkg;

    localparam int ADDR_W_DEF   = 16;
    localparam int DATA_W_DEF   = 8;
    localparam int DEPTH_DEF    = 8;
    localparam int WIN_LO_DEF   = 'h0400;
    localparam int WIN_HI_DEF   = 'h1000;
    localparam logic [7:0] MARK_OPEN_DEF  = 8'hB2;
    localparam logic [7:0] MARK_CTRL_DEF  = 8'h00;
    localparam logic [7:0] MARK_CLOSE_DEF = 8'h4D;

    typedef enum logic [2:0] {
        S_IDLE,
        S_PRE_REQ,
        S_PRE_CHK,
        S_CTRL_REQ,
        S_CTRL_CHK,
        S_POST_REQ,
        S_POST_CHK,
        S_DONE
    } scan_state_e;

endpackage

// File: rtl/bsdir_match.sv
module bsdir_match #(
    parameter int              DW         = 8,
    parameter logic [DW-1:0]   MARK_OPEN  = 8'hB2,
    parameter logic [DW-1:0]   MARK_CTRL  = 8'h00,
    parameter logic [DW-1:0]   MARK_CLOSE = 8'h4D
) (
    input  logic [DW-1:0] rdata,
    output logic          hit_open,
    output logic          hit_ctrl,
    output logic          hit_close
);

    always_comb begin
        hit_open  = (rdata == MARK_OPEN);
        hit_ctrl  = (rdata == MARK_CTRL);
        hit_close = (rdata == MARK_CLOSE);
    end

endmodule

// File: rtl/bsdir_fsm.sv
module bsdir_fsm
    import bsdir_pkg::*;
#(
    parameter int AW     = 16,
    parameter int WIN_LO = 'h0400,
    parameter int WIN_HI = 'h1000
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          start,
    input  logic          hit_open,
    input  logic          hit_ctrl,
    input  logic          hit_close,
    output logic          mem_rd,
    output logic [AW-1:0] mem_addr,
    output logic          busy,
    output logic          done,
    output logic          rec,
    output logic [AW-1:0] rec_addr
);

    localparam logic [AW:0] LO_W = WIN_LO[AW:0];
    localparam logic [AW:0] HI_W = WIN_HI[AW:0];

    scan_state_e   state, state_d;
    logic [AW-1:0] addr, addr_d;
    logic [AW:0]   step1, step2;
    logic          end1, end2;

    always_comb begin
        step1 = {1'b0, addr} + (AW+1)'(1);
        step2 = {1'b0, addr} + (AW+1)'(2);
        end1  = (step1 >= HI_W);
        end2  = (step2 >= HI_W);
    end

    // next-state and next-address logic
    always_comb begin
        state_d = state;
        addr_d  = addr;
        if (start) begin
            state_d = S_PRE_REQ;
            addr_d  = LO_W[AW-1:0];
        end else begin
            unique case (state)
                S_IDLE:     state_d = S_IDLE;
                S_DONE:     state_d = S_DONE;
                S_PRE_REQ:  state_d = S_PRE_CHK;
                S_CTRL_REQ: state_d = S_CTRL_CHK;
                S_POST_REQ: state_d = S_POST_CHK;
                S_PRE_CHK: begin
                    if (end1) begin
                        state_d = S_DONE;
                    end else begin
                        addr_d  = step1[AW-1:0];
                        state_d = hit_open ? S_CTRL_REQ : S_PRE_REQ;
                    end
                end
                S_CTRL_CHK: begin
                    if (end1) begin
                        state_d = S_DONE;
                    end else begin
                        addr_d  = step1[AW-1:0];
                        state_d = hit_ctrl ? S_POST_REQ : S_CTRL_REQ;
                    end
                end
                S_POST_CHK: begin
                    if (end1) begin
                        state_d = S_DONE;
                    end else if (hit_close) begin
                        if (end2) begin
                            state_d = S_DONE;
                        end else begin
                            addr_d  = step2[AW-1:0];
                            state_d = S_PRE_REQ;
                        end
                    end else begin
                        addr_d  = step1[AW-1:0];
                        state_d = S_POST_REQ;
                    end
                end
                default: state_d = S_IDLE;
            endcase
        end
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state <= S_IDLE;
            addr  <= LO_W[AW-1:0];
        end else begin
            state <= state_d;
            addr  <= addr_d;
        end
    end

    // outputs
    always_comb begin
        mem_rd   = (state == S_PRE_REQ) || (state == S_CTRL_REQ) || (state == S_POST_REQ);
        mem_addr = addr;
        busy     = (state != S_IDLE) && (state != S_DONE);
        done     = (state == S_DONE);
        rec      = (state == S_PRE_CHK) && !start && !end1 && hit_open;
        rec_addr = step1[AW-1:0];
    end

    AST_RD_IN_WINDOW: assert property (@(posedge clk) disable iff (!rst_n)
        mem_rd |-> ({1'b0, mem_addr} >= LO_W) && ({1'b0, mem_addr} < HI_W)); // R3

    AST_CHK_AFTER_REQ: assert property (@(posedge clk) disable iff (!rst_n)
        ((state == S_PRE_CHK) || (state == S_CTRL_CHK) || (state == S_POST_CHK)) |-> $past(mem_rd)); // R3

    AST_ADDR_ASCENDS: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && !start) |=> (mem_addr >= $past(mem_addr))); // R3

    AST_DONE_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        (done && !start) |=> done); // R9

    AST_START_FIRST_READ: assert property (@(posedge clk) disable iff (!rst_n)
        start |=> (mem_rd && (mem_addr == LO_W[AW-1:0]))); // R2

endmodule

// File: rtl/bsdir_table.sv
module bsdir_table #(
    parameter int AW    = 16,
    parameter int DEPTH = 8,
    localparam int SW   = (DEPTH > 1) ? $clog2(DEPTH) : 1,
    localparam int CW   = $clog2(DEPTH + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          clr,
    input  logic          rec,
    input  logic [AW-1:0] rec_addr,
    input  logic [SW-1:0] sel,
    output logic [AW-1:0] rd_ptr,
    output logic [CW-1:0] count,
    output logic          overflow
);

    localparam logic [CW-1:0] FULL_C = CW'(DEPTH);

    logic [AW-1:0] ent [DEPTH];
    logic          full;

    assign full = (count == FULL_C);

    for (genvar g = 0; g < DEPTH; g++) begin : g_ent
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                ent[g] <= '0;
            end else if (clr) begin
                ent[g] <= '0;
            end else if (rec && !full && (count == CW'(g))) begin
                ent[g] <= rec_addr;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            count    <= '0;
            overflow <= 1'b0;
        end else if (clr) begin
            count    <= '0;
            overflow <= 1'b0;
        end else if (rec) begin
            if (full) overflow <= 1'b1;
            else      count    <= count + CW'(1);
        end
    end

    always_comb begin
        rd_ptr = '0;
        if ({1'b0, sel} < {1'b0, count}) rd_ptr = ent[sel];
    end

    AST_COUNT_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
        count <= FULL_C); // R8

    AST_OVF_ONLY_FULL: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(overflow) |-> (count == FULL_C)); // R8

    AST_CLEAR_ON_START: assert property (@(posedge clk) disable iff (!rst_n)
        clr |=> ((count == '0) && !overflow)); // R2

    AST_COUNT_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        (rec && !clr && !full) |=> (count == $past(count) + CW'(1))); // R4

endmodule

// File: rtl/bsdir_scan.sv
module bsdir_scan
    import bsdir_pkg::*;
#(
    parameter int         AW         = ADDR_W_DEF,
    parameter int         DW         = DATA_W_DEF,
    parameter int         DEPTH      = DEPTH_DEF,
    parameter int         WIN_LO     = WIN_LO_DEF,
    parameter int         WIN_HI     = WIN_HI_DEF,
    parameter logic [7:0] MARK_OPEN  = MARK_OPEN_DEF,
    parameter logic [7:0] MARK_CTRL  = MARK_CTRL_DEF,
    parameter logic [7:0] MARK_CLOSE = MARK_CLOSE_DEF,
    localparam int        SW         = (DEPTH > 1) ? $clog2(DEPTH) : 1,
    localparam int        CW         = $clog2(DEPTH + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          start,
    output logic          mem_rd,
    output logic [AW-1:0] mem_addr,
    input  logic [DW-1:0] mem_rdata,
    output logic          busy,
    output logic          done,
    output logic [CW-1:0] count,
    output logic          overflow,
    input  logic [SW-1:0] tbl_sel,
    output logic [AW-1:0] tbl_ptr
);

    logic          hit_open, hit_ctrl, hit_close;
    logic          rec;
    logic [AW-1:0] rec_addr;

    bsdir_match #(
        .DW(DW),
        .MARK_OPEN(DW'(MARK_OPEN)),
        .MARK_CTRL(DW'(MARK_CTRL)),
        .MARK_CLOSE(DW'(MARK_CLOSE))
    ) u_match (
        .rdata(mem_rdata),
        .hit_open(hit_open),
        .hit_ctrl(hit_ctrl),
        .hit_close(hit_close)
    );

    bsdir_fsm #(
        .AW(AW),
        .WIN_LO(WIN_LO),
        .WIN_HI(WIN_HI)
    ) u_fsm (
        .clk(clk),
        .rst_n(rst_n),
        .start(start),
        .hit_open(hit_open),
        .hit_ctrl(hit_ctrl),
        .hit_close(hit_close),
        .mem_rd(mem_rd),
        .mem_addr(mem_addr),
        .busy(busy),
        .done(done),
        .rec(rec),
        .rec_addr(rec_addr)
    );

    bsdir_table #(
        .AW(AW),
        .DEPTH(DEPTH)
    ) u_table (
        .clk(clk),
        .rst_n(rst_n),
        .clr(start),
        .rec(rec),
        .rec_addr(rec_addr),
        .sel(tbl_sel),
        .rd_ptr(tbl_ptr),
        .count(count),
        .overflow(overflow)
    );

endmodule

// File: tb/test_bsdir_scan.sv
module test_bsdir_scan;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic        mem_rd;
    logic [15:0] mem_addr;
    logic [7:0]  mem_rdata = 8'h00;
    logic        busy, done, overflow;
    logic [3:0]  count;
    logic [2:0]  tbl_sel = 3'd0;
    logic [15:0] tbl_ptr;

    always #5 clk = ~clk;

    bsdir_scan i_bsdir_scan (
        .clk(clk), .rst_n(rst_n), .start(start),
        .mem_rd(mem_rd), .mem_addr(mem_addr), .mem_rdata(mem_rdata),
        .busy(busy), .done(done), .count(count), .overflow(overflow),
        .tbl_sel(tbl_sel), .tbl_ptr(tbl_ptr)
    );

    logic [7:0]  mem [0:4095];
    always @(posedge clk) if (mem_rd) mem_rdata <= mem[mem_addr[11:0]];

    int n_chk = 0;
    int n_fail = 0;

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
        end
    endtask

    // read-address monitor for R3
    int   scan_gen = 0;
    int   mon_gen = -1;
    int   mon_bad = 0;
    int   last_a = 0;
    always @(negedge clk) begin
        if (rst_n && mem_rd) begin
            if (mon_gen != scan_gen) begin
                mon_gen = scan_gen;
                last_a = -1;
            end
            if (mem_addr < 16'h0400 || mem_addr >= 16'h1000 || int'(mem_addr) <= last_a)
                mon_bad++;
            last_a = int'(mem_addr);
        end
    end

    // reference model
    int exp_tbl [8];
    int exp_cnt;
    bit exp_ovf;

    task automatic model();
        int a;
        int ph;
        for (int i = 0; i < 8; i++) exp_tbl[i] = 0;
        exp_cnt = 0; exp_ovf = 0; a = 'h0400; ph = 0;
        while (1) begin
            if (a + 1 >= 'h1000) break;
            if (ph == 0) begin
                if (mem[a] == 8'hB2) begin
                    if (exp_cnt < 8) begin exp_tbl[exp_cnt] = a + 1; exp_cnt++; end
                    else exp_ovf = 1;
                    ph = 1;
                end
                a = a + 1;
            end else if (ph == 1) begin
                if (mem[a] == 8'h00) ph = 2;
                a = a + 1;
            end else begin
                if (mem[a] == 8'h4D) begin
                    a = a + 2;
                    if (a >= 'h1000) break;
                    ph = 0;
                end else a = a + 1;
            end
        end
    endtask

    task automatic fill(input logic [7:0] v);
        for (int i = 0; i < 4096; i++) mem[i] = v;
    endtask

    task automatic fill_rand();
        for (int i = 0; i < 4096; i++) mem[i] = 8'($urandom);
    endtask

    task automatic put_bs(input int a, input int len);
        mem[a] = 8'hB2;
        for (int i = 1; i < len - 1; i++) mem[a + i] = 8'h11;
        mem[a + len / 2] = 8'h00;
        mem[a + len - 1] = 8'h4D;
    endtask

    task automatic pulse_start();
        @(negedge clk);
        start = 1'b1;
        scan_gen++;
        mon_bad = 0;
        @(negedge clk);
        start = 1'b0;
    endtask

    task automatic run_scan(input string tag);
        int t;
        model();
        pulse_start();
        chk(mem_rd && mem_addr == 16'h0400 && count == 0 && !overflow, "R2 first read", mem_addr, 'h0400);
        t = 0;
        while (!done && t < 20000) begin @(negedge clk); t++; end
        chk(done && !busy, {"R7 scan ends ", tag}, done, 1);
        chk(mon_bad == 0, {"R3 read order ", tag}, mon_bad, 0);
        chk(count == 4'(exp_cnt), {"R4 count ", tag}, count, exp_cnt);
        chk(overflow == exp_ovf, {"R8 overflow ", tag}, overflow, exp_ovf);
        for (int i = 0; i < 8; i++) begin
            tbl_sel = 3'(i);
            #1;
            chk(int'(tbl_ptr) == exp_tbl[i], {"R4 R9 entry ", tag}, tbl_ptr, exp_tbl[i]);
        end
        repeat (3) @(negedge clk);
        chk(done && count == 4'(exp_cnt), {"R9 hold ", tag}, count, exp_cnt);
    endtask

    initial begin
        int unused_seed;
        unused_seed = $urandom(32'h5EED_0042);
        fill(8'hFF);
        repeat (3) @(negedge clk);
        // R1 reset state
        chk(!done && !busy && !mem_rd && !overflow && count == 0, "R1 reset", count, 0);
        tbl_sel = 3'd0; #1;
        chk(tbl_ptr == 16'h0, "R1 table", tbl_ptr, 0);
        rst_n = 1'b1;
        @(negedge clk);
        chk(!done && !busy && !mem_rd, "R1 idle", busy, 0);

        // R5 R6: markers in the wrong phase, first byte preamble, skipped byte after postamble
        fill(8'hFF);
        mem['h400] = 8'hB2; mem['h405] = 8'hB2; mem['h406] = 8'h00;
        mem['h407] = 8'hB2; mem['h408] = 8'h4D; mem['h409] = 8'hB2;
        mem['h40A] = 8'hB2; mem['h40B] = 8'h00; mem['h40C] = 8'h4D; mem['h40E] = 8'h4D;
        put_bs('h500, 40);
        run_scan("phases");
        tbl_sel = 3'd1; #1;
        chk(tbl_ptr == 16'h040B, "R6 resume after skip", tbl_ptr, 'h40B);
        chk(count == 4'd3, "R5 ignored in-phase preambles", count, 3);

        // R7: preamble in the last byte is not examined
        fill(8'hFF); mem['hFFF] = 8'hB2;
        run_scan("last byte");
        chk(count == 0, "R7 last byte unexamined", count, 0);

        // R7: truncated bitstream and preamble at 0x0FFE
        fill(8'hFF); mem['hFF0] = 8'hB2; mem['hFF2] = 8'h00;
        run_scan("truncated");
        fill(8'hFF); mem['hFFE] = 8'hB2;
        run_scan("penultimate");
        tbl_sel = 3'd0; #1;
        chk(tbl_ptr == 16'h0FFF, "R7 penultimate preamble", tbl_ptr, 'hFFF);

        // R6 R7: postamble skip landing at the boundary
        fill(8'hFF); mem['hF00] = 8'hB2; mem['hF01] = 8'h00; mem['hFFE] = 8'h4D;
        run_scan("skip to end");
        fill(8'hFF); mem['hF00] = 8'hB2; mem['hF01] = 8'h00; mem['hFFD] = 8'h4D; mem['hFFF] = 8'hB2;
        run_scan("skip near end");

        // R8: more bitstreams than entries
        fill(8'hFF);
        for (int k = 0; k < 10; k++) put_bs('h400 + k * 'h100, 20 + k);
        run_scan("overflow");
        chk(overflow && count == 4'd8, "R8 full table", count, 8);

        // R10: restart mid-scan
        pulse_start();
        chk(count == 0 && !overflow, "R10 cleared on restart", count, 0);
        repeat (300) @(negedge clk);
        run_scan("restart");

        // constrained random images
        for (int r = 0; r < 6; r++) begin
            int a;
            if (r % 2 == 0) fill_rand(); else fill(8'($urandom_range(1, 255)));
            a = 'h400 + int'($urandom_range(0, 63));
            for (int k = 0; k < 7 && a < 'hF80; k++) begin
                put_bs(a, int'($urandom_range(6, 90)));
                a = a + 100 + int'($urandom_range(0, 300));
            end
            run_scan("random");
        end

        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
        $finish;
    end

    initial begin
        #1_800_000;
        n_chk++; n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
        $finish;
    end

endmodule